// File: doc/BRIEF.md
# Byte-wide SPI master/slave port

This block moves one byte at a time over a four-wire SPI link and exchanges data in both directions at once. A single shift register sends its most significant bit first on the data-out pin while it takes the data-in pin in at bit 0. The host never touches that shift register directly. A host write loads it and starts a transfer. When the last bit arrives, the received byte is copied into a buffer that the host reads.

A 4-bit mode code selects the role of the port. As a master, the port drives the serial clock from one of four sources: the system clock divided by 4, 16 or 64, or an external timer tick divided by 2. As a slave, the port follows an external serial clock and can honour a select input. Raising that select input drops a partial byte and releases the data-out pin. Two configuration inputs choose the idle level of the clock and the clock edge on which data changes. Completion sets a buffer-full flag and raises a one-cycle interrupt pulse. Two error conditions raise sticky flags: a byte that completes while the buffer is still full, and a host write made in the middle of a transfer.

Top module: `spi_port`

## Requirements
- R1: Mode codes 0000 to 0011 select master mode, with sck_oe=1 and sdo_oe=1. Code 0100 selects slave mode with select control. Code 0101 selects slave mode without select control. Every other code leaves the port idle: sck_oe=0, sdo_oe=0, sck_out held at the idle level, host writes ignored and no transfer started.
- R2: In master mode, sck_out changes level every 2, 8 or 32 system clocks for codes 0000, 0001 and 0010. For code 0011 it changes level once per tmr_tick pulse. A byte takes exactly 16 level changes, and between bytes sck_out rests at the idle level ckp.
- R3: A transfer is full duplex and MSB first. sdo presents wr_data bit 7 first, and each sampled sdi bit enters at bit 0. With sdo looped back to sdi, a master transfer returns the written byte.
- R4: With cke=1, data is sampled on the idle-to-active edge and changes on the active-to-idle edge. With cke=0 the two edges swap. A byte completes on its 8th sampling edge. In master mode, full rises 15*H system clocks after the write with cke=1 and 16*H with cke=0, where H is the half period in clocks. In timer mode it rises on the 15th or 16th tick.
- R5: On completion, when the buffer is empty, the received byte appears on rd_data and buf_full rises. irq is high for exactly that one cycle. Pulsing rd_en clears buf_full.
- R6: If a byte completes while buf_full is still set, overflow is set and rd_data keeps the older byte.
- R7: A write during a transfer sets wr_collision and does not disturb the byte being sent. A master transfer is in progress while its clock runs, and a slave transfer is in progress once a bit has been sampled.
- R8: In mode 0100, a high ss_in clears the bit counter so that a partial byte never completes, ignores serial clock edges and forces sdo_oe=0. Once ss_in goes low again, a fresh write and 8 bits give a correct byte.
- R9: In mode 0101, ss_in is ignored: sdo_oe stays 1 and transfers complete with ss_in high.
- R10: Pulsing clr_err clears overflow and wr_collision and takes priority over setting them in the same cycle.
- R11: After reset, buf_full, overflow, wr_collision and irq are 0 and rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | Role and clock-source code |
| cke | input | 1 | Edge select: 1 samples on idle-to-active |
| ckp | input | 1 | Idle level of the serial clock |
| wr_en | input | 1 | Host write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Host read strobe, clears buf_full |
| clr_err | input | 1 | Clears overflow and wr_collision |
| rd_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| overflow | output | 1 | Sticky: byte completed while buffer was full |
| wr_collision | output | 1 | Sticky: write made during a transfer |
| irq | output | 1 | One-cycle completion pulse |
| tmr_tick | input | 1 | Timer tick for the slowest master clock source |
| sck_in | input | 1 | Serial clock from the master (slave mode) |
| sck_out | output | 1 | Generated serial clock (master mode) |
| sck_oe | output | 1 | Drive enable for sck_out |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for sdo |
| ss_in | input | 1 | Slave select, high deselects |

## Verification
In master mode, buf_full and irq are due exactly 15*H or 16*H cycles after the write is taken, or on the 15th or 16th tick in timer mode. The bench counts cycles and ticks from that write and compares the count where buf_full is first seen high. irq must be gone one cycle after it rose, and wr_collision is due one cycle after the offending write. Slave inputs pass through a two-stage synchronizer and an edge register, so slave results and sdo_oe changes are due within three clocks. The bench holds every serial clock phase for ten clocks and waits at least six clocks after a select change before it samples.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef enum logic [1:0] {
    ROLE_OFF        = 2'd0,
    ROLE_MASTER     = 2'd1,
    ROLE_SLAVE_SEL  = 2'd2,
    ROLE_SLAVE_FREE = 2'd3
  } role_e;

  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_MID  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_TICK = 2'd3
  } clk_src_e;

  typedef struct packed {
    role_e    role;
    clk_src_e src;
  } port_cfg_s;

  function automatic port_cfg_s decode_mode(input logic [3:0] code);
    port_cfg_s c;
    c.role = ROLE_OFF;
    c.src  = SRC_FAST;
    if (code[3:2] == 2'b00) begin
      c.role = ROLE_MASTER;
      c.src  = clk_src_e'(code[1:0]);
    end else if (code == 4'b0100) begin
      c.role = ROLE_SLAVE_SEL;
    end else if (code == 4'b0101) begin
      c.role = ROLE_SLAVE_FREE;
    end
    return c;
  endfunction

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic [BITS-1:0] load_data,
  input  logic            smp,
  input  logic            lnc,
  input  logic            sdi,
  output logic            sdo,
  output logic            mid,
  output logic            done,
  output logic [BITS-1:0] rx_word
);
  localparam int CW = $clog2(BITS);

  logic [BITS-1:0] sh_q, sh_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            sdo_q, sdo_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    sdo_d = sdo_q;
    done  = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (load) begin
      sh_d  = load_data;
      sdo_d = load_data[BITS-1];
    end else begin
      if (smp) begin
        sh_d = {sh_q[BITS-2:0], sdi};
        if (cnt_q == CW'(BITS-1)) begin
          cnt_d = '0;
          done  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (lnc) sdo_d = sh_q[BITS-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      sdo_q <= sdo_d;
    end
  end

  assign rx_word = {sh_q[BITS-2:0], sdi};
  assign sdo     = sdo_q;
  assign mid     = (cnt_q != '0);
endmodule

// File: rtl/spi_port_sckgen.sv
module spi_port_sckgen
  import spi_port_pkg::*;
#(
  parameter int BITS     = 8,
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     stop,
  input  clk_src_e src,
  input  logic     tmr_tick,
  output logic     phase,
  output logic     lead,
  output logic     trail,
  output logic     busy
);
  localparam int CW    = $clog2(DIV_SLOW / 2) + 1;
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES);

  logic [CW-1:0] div_q, div_d, half_m1;
  logic [EW-1:0] tog_q, tog_d;
  logic          ph_q, ph_d, busy_q, busy_d, step;

  always_comb begin
    case (src)
      SRC_FAST: half_m1 = CW'(DIV_FAST / 2 - 1);
      SRC_MID:  half_m1 = CW'(DIV_MID / 2 - 1);
      default:  half_m1 = CW'(DIV_SLOW / 2 - 1);
    endcase
  end

  assign step = busy_q && ((src == SRC_TICK) ? tmr_tick : (div_q == half_m1));

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    div_d  = div_q;
    tog_d  = tog_q;
    if (stop) begin
      busy_d = 1'b0;
      ph_d   = 1'b0;
      div_d  = '0;
      tog_d  = '0;
    end else if (start) begin
      busy_d = 1'b1;
      ph_d   = 1'b0;
      div_d  = '0;
      tog_d  = '0;
    end else if (step) begin
      ph_d  = ~ph_q;
      div_d = '0;
      tog_d = tog_q + 1'b1;
      if (tog_q == EW'(EDGES - 1)) busy_d = 1'b0;
    end else if (busy_q) begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      div_q  <= '0;
      tog_q  <= '0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      div_q  <= div_d;
      tog_q  <= tog_d;
    end
  end

  assign lead  = step && !ph_q && !stop;
  assign trail = step && ph_q && !stop;
  assign phase = ph_q;
  assign busy  = busy_q;
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int BITS        = 8,
  parameter int DIV_FAST    = 4,
  parameter int DIV_MID     = 16,
  parameter int DIV_SLOW    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      mode,
  input  logic            cke,
  input  logic            ckp,
  input  logic            wr_en,
  input  logic [BITS-1:0] wr_data,
  input  logic            rd_en,
  input  logic            clr_err,
  output logic [BITS-1:0] rd_data,
  output logic            buf_full,
  output logic            overflow,
  output logic            wr_collision,
  output logic            irq,
  input  logic            tmr_tick,
  input  logic            sck_in,
  output logic            sck_out,
  output logic            sck_oe,
  input  logic            sdi,
  output logic            sdo,
  output logic            sdo_oe,
  input  logic            ss_in
);
  localparam int NPINS = 3;

  port_cfg_s cfg;
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  logic [NPINS-1:0] pin_raw, pin_s;
  logic sck_s, ss_hi, sdi_s, sck_p;
  logic is_master, is_slave, slave_live;
  logic s_edge, s_lead, s_trail, g_lead, g_trail, g_phase, g_busy;
  logic lead, trail, smp, lnc, xfer_busy, wr_ok, wr_bad, sh_clr, sdi_use;
  logic sh_mid, done;
  logic [BITS-1:0] rx_word;
  logic [BITS-1:0] buf_q, buf_d;
  logic full_q, full_d, ovf_q, ovf_d, wcol_q, wcol_d, irq_q, irq_d;

  assign cfg = decode_mode(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign pin_raw = {ss_in, sck_in, sdi};
  for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin_sync
    spi_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_core_n), .d(pin_raw[gi]), .q(pin_s[gi]));
  end
  assign sdi_s = pin_s[0];
  assign sck_s = pin_s[1];
  assign ss_hi = pin_s[2];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) sck_p <= 1'b0;
    else             sck_p <= sck_s;
  end

  assign is_master  = (cfg.role == ROLE_MASTER);
  assign is_slave   = (cfg.role == ROLE_SLAVE_SEL) || (cfg.role == ROLE_SLAVE_FREE);
  assign slave_live = is_slave && !((cfg.role == ROLE_SLAVE_SEL) && ss_hi);
  assign s_edge     = slave_live && (sck_s != sck_p);
  assign s_lead     = s_edge && (sck_s != ckp);
  assign s_trail    = s_edge && (sck_s == ckp);

  assign lead      = is_master ? g_lead  : s_lead;
  assign trail     = is_master ? g_trail : s_trail;
  assign smp       = cke ? lead  : trail;
  assign lnc       = cke ? trail : lead;
  assign xfer_busy = is_master ? g_busy : sh_mid;
  assign wr_ok     = wr_en && (cfg.role != ROLE_OFF) && !xfer_busy;
  assign wr_bad    = wr_en && (cfg.role != ROLE_OFF) && xfer_busy;
  assign sh_clr    = (cfg.role == ROLE_OFF) || ((cfg.role == ROLE_SLAVE_SEL) && ss_hi);
  assign sdi_use   = is_master ? sdi : sdi_s;

  spi_port_sckgen #(
    .BITS(BITS), .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) u_sckgen (
    .clk(clk), .rst_n(rst_core_n), .start(wr_ok && is_master), .stop(!is_master),
    .src(cfg.src), .tmr_tick(tmr_tick), .phase(g_phase), .lead(g_lead),
    .trail(g_trail), .busy(g_busy));

  spi_port_shifter #(.BITS(BITS)) u_shifter (
    .clk(clk), .rst_n(rst_core_n), .clr(sh_clr), .load(wr_ok), .load_data(wr_data),
    .smp(smp), .lnc(lnc), .sdi(sdi_use), .sdo(sdo), .mid(sh_mid), .done(done),
    .rx_word(rx_word));

  always_comb begin
    buf_d  = buf_q;
    full_d = full_q;
    ovf_d  = ovf_q;
    wcol_d = wcol_q;
    irq_d  = done;
    if (rd_en)  full_d = 1'b0;
    if (wr_bad) wcol_d = 1'b1;
    if (done) begin
      if (full_q && !rd_en) begin
        ovf_d = 1'b1;
      end else begin
        buf_d  = rx_word;
        full_d = 1'b1;
      end
    end
    if (clr_err) begin
      ovf_d  = 1'b0;
      wcol_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
      wcol_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      full_q <= full_d;
      ovf_q  <= ovf_d;
      wcol_q <= wcol_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    case (cfg.role)
      ROLE_MASTER, ROLE_SLAVE_FREE: sdo_oe = 1'b1;
      ROLE_SLAVE_SEL:               sdo_oe = !ss_hi;
      default:                      sdo_oe = 1'b0;
    endcase
  end

  assign sck_out      = is_master ? (g_phase ^ ckp) : ckp;
  assign sck_oe       = is_master;
  assign rd_data      = buf_q;
  assign buf_full     = full_q;
  assign overflow     = ovf_q;
  assign wr_collision = wcol_q;
  assign irq          = irq_q;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int BITS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      mode,
  input logic            wr_en,
  input logic            clr_err,
  input logic [BITS-1:0] rd_data,
  input logic            buf_full,
  input logic            overflow,
  input logic            wr_collision,
  input logic            irq,
  input logic            sck_oe,
  input logic            sdo_oe,
  input logic            ss_in
);
  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_rst <= '0;
    else if (since_rst != 3'd7)  since_rst <= since_rst + 1'b1;
  end

  // R1: idle codes release both drivers
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3] || (mode[3:1] == 3'b011)) |-> (!sck_oe && !sdo_oe));

  // R1: master codes drive clock and data
  assert_master_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] == 2'b00) |-> (sck_oe && sdo_oe));

  // R5: interrupt lasts one cycle
  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5: buffer fills together with the interrupt
  assert_full_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> irq);

  // R6: overflow keeps the older byte
  assert_keep_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($stable(rd_data) && buf_full));

  // R7: a collision only follows a write
  assert_wcol_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_collision) |-> $past(wr_en));

  // R8: a settled high select releases data-out
  assert_ss_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst == 3'd7) && (mode == 4'b0100) && ($past(mode) == 4'b0100) &&
     ($past(mode, 2) == 4'b0100) && ss_in && $past(ss_in) && $past(ss_in, 2) &&
     $past(ss_in, 3)) |-> !sdo_oe);

  // R10: clearing wins over setting
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> (!overflow && !wr_collision));
endmodule

bind spi_port spi_port_chk #(.BITS(BITS)) u_chk (.*);

// File: tb/spi_port_test.sv
`timescale 1ns/1ps
module spi_port_test;
  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] mode;
  logic cke, ckp, wr_en, rd_en, clr_err, tmr_tick;
  logic [7:0] wr_data, rd_data;
  logic buf_full, overflow, wr_collision, irq;
  logic sck_in, sck_out, sck_oe, sdi, sdo, sdo_oe, ss_in;
  logic lb, s_sdi;
  int checks = 0;
  int fails = 0;
  int tick_ph = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign sdi = lb ? sdo : s_sdi;

  spi_port uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cke(cke), .ckp(ckp), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .clr_err(clr_err), .rd_data(rd_data),
    .buf_full(buf_full), .overflow(overflow), .wr_collision(wr_collision), .irq(irq),
    .tmr_tick(tmr_tick), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .ss_in(ss_in));

  always @(posedge clk) begin
    #1;
    tick_ph  = (tick_ph == 2) ? 0 : tick_ph + 1;
    tmr_tick = (tick_ph == 0);
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic host_clear();
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
  endtask

  task automatic wait_full();
    int guard = 0;
    while (!buf_full && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  task automatic set_cfg(input logic [3:0] m, input logic e, input logic p);
    mode = 4'b1000;
    @(negedge clk); cke = e; ckp = p; sck_in = p;
    repeat (6) @(negedge clk);
    mode = m;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_master(input logic [3:0] m, input logic e, input logic p,
                            input logic [7:0] d);
    int half, k, cycles, ticks, togs, guard, extra;
    logic prev;
    half = (m == 4'd0) ? 2 : (m == 4'd1) ? 8 : 32;
    k    = e ? 15 : 16;
    lb   = 1'b1;
    set_cfg(m, e, p);
    check("R1 master sck_oe", sck_oe, 1);
    check("R2 idle level before", sck_out, p);
    host_write(d);
    cycles = 0; ticks = 0; togs = 0; guard = 0; prev = sck_out;
    while (!buf_full && guard < 5000) begin
      if (tmr_tick) ticks++;
      cycles++;
      @(negedge clk);
      if (sck_out !== prev) togs++;
      prev = sck_out;
      guard++;
    end
    if (m == 4'd3) check("R2 ticks to completion", ticks, k);
    else           check("R4 cycles to completion", cycles, k * half);
    check("R5 irq with full", irq, 1);
    check("R3 loopback byte", rd_data, d);
    extra = (m == 4'd3) ? 40 : 2 * half + 4;
    for (int i = 0; i < extra; i++) begin
      @(negedge clk);
      if (i == 0) check("R5 irq one cycle", irq, 0);
      if (sck_out !== prev) togs++;
      prev = sck_out;
    end
    check("R2 level changes per byte", togs, 16);
    check("R2 idle level after", sck_out, p);
    host_read();
    check("R5 read clears full", buf_full, 0);
  endtask

  task automatic slave_bits(input logic [7:0] rxb, input int nbits, input logic e,
                            input logic p, output logic [7:0] seen);
    seen = 8'h00;
    for (int b = 0; b < nbits; b++) begin
      s_sdi = rxb[7 - b];
      if (!e) begin
        sck_in = ~p;
        repeat (10) @(negedge clk);
        seen[7 - b] = sdo;
        sck_in = p;
        repeat (10) @(negedge clk);
      end else begin
        repeat (10) @(negedge clk);
        seen[7 - b] = sdo;
        sck_in = ~p;
        repeat (10) @(negedge clk);
        sck_in = p;
        repeat (10) @(negedge clk);
      end
    end
  endtask

  task automatic run_slave(input logic [3:0] m, input logic e, input logic p,
                           input logic [7:0] tx, input logic [7:0] rxb);
    logic [7:0] seen;
    lb = 1'b0;
    set_cfg(m, e, p);
    host_write(tx);
    check("R7 no collision when idle", wr_collision, 0);
    slave_bits(rxb, 8, e, p, seen);
    repeat (4) @(negedge clk);
    check("R4 slave completes on 8th sample edge", buf_full, 1);
    check("R3 slave receive", rd_data, rxb);
    check("R3 slave MSB-first send", seen, tx);
    host_read();
  endtask

  initial begin
    logic [7:0] seen;
    int guard;
    rst_n = 1'b0; mode = 4'b1000; cke = 1'b0; ckp = 1'b0; wr_en = 1'b0;
    wr_data = 8'h00; rd_en = 1'b0; clr_err = 1'b0; sck_in = 1'b0; ss_in = 1'b0;
    lb = 1'b0; s_sdi = 1'b0; tmr_tick = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 full after reset", buf_full, 0);
    check("R11 overflow after reset", overflow, 0);
    check("R11 collision after reset", wr_collision, 0);
    check("R11 irq after reset", irq, 0);
    check("R11 buffer after reset", rd_data, 0);

    // R1: an idle code ignores writes
    set_cfg(4'b1000, 1'b0, 1'b1);
    host_write(8'hFF);
    repeat (100) @(negedge clk);
    check("R1 idle no completion", buf_full, 0);
    check("R1 idle sck_oe", sck_oe, 0);
    check("R1 idle sdo_oe", sdo_oe, 0);
    check("R1 idle clock level", sck_out, 1);
    check("R1 idle no collision", wr_collision, 0);
    mode = 4'b0110;
    repeat (2) @(negedge clk);
    check("R1 code 0110 sdo_oe", sdo_oe, 0);

    // R2 R4: every clock source, edge and polarity
    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 2; e++)
        for (int p = 0; p < 2; p++)
          run_master(4'(m), 1'(e), 1'(p), 8'h5A ^ 8'(m * 37 + e * 11 + p * 5));

    // R3: every byte value through the fastest master setting
    for (int v = 0; v < 256; v++) run_master(4'd0, 1'b0, 1'b0, 8'(v));

    // R6: second byte while the first is unread
    lb = 1'b1;
    set_cfg(4'd0, 1'b0, 1'b0);
    host_write(8'hC3);
    wait_full();
    host_write(8'h3C);
    guard = 0;
    while (!irq && guard < 5000) begin @(negedge clk); guard++; end
    check("R6 overflow set", overflow, 1);
    check("R6 buffer keeps old byte", rd_data, 8'hC3);
    check("R6 still full", buf_full, 1);
    host_read();
    host_clear();
    check("R10 overflow cleared", overflow, 0);

    // R7: write in the middle of a master transfer
    host_write(8'h96);
    repeat (5) @(negedge clk);
    host_write(8'h0F);
    check("R7 collision flagged", wr_collision, 1);
    wait_full();
    check("R7 byte in flight undisturbed", rd_data, 8'h96);
    host_read();
    host_clear();
    check("R10 collision cleared", wr_collision, 0);

    // R3 R4: slave with select control, both edges and polarities
    ss_in = 1'b0;
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 2; p++)
        run_slave(4'b0100, 1'(e), 1'(p), 8'hB1 ^ 8'(e * 6 + p * 3), 8'h4E ^ 8'(e * 9 + p * 17));

    // R8: select high mid-byte drops the partial byte
    lb = 1'b0;
    set_cfg(4'b0100, 1'b0, 1'b0);
    host_write(8'hE7);
    slave_bits(8'hFF, 3, 1'b0, 1'b0, seen);
    ss_in = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 sdo released", sdo_oe, 0);
    slave_bits(8'hFF, 6, 1'b0, 1'b0, seen);
    check("R8 clock ignored while deselected", buf_full, 0);
    ss_in = 1'b0;
    repeat (6) @(negedge clk);
    check("R8 sdo driven again", sdo_oe, 1);
    host_write(8'h29);
    check("R8 counter cleared, write accepted", wr_collision, 0);
    slave_bits(8'hD4, 8, 1'b0, 1'b0, seen);
    repeat (4) @(negedge clk);
    check("R8 fresh byte completes", buf_full, 1);
    check("R8 fresh byte received", rd_data, 8'hD4);
    check("R8 fresh byte sent", seen, 8'h29);
    host_read();

    // R9: slave without select control
    ss_in = 1'b1;
    set_cfg(4'b0101, 1'b0, 1'b1);
    check("R9 sdo_oe with ss high", sdo_oe, 1);
    host_write(8'h71);
    slave_bits(8'h8A, 8, 1'b0, 1'b1, seen);
    repeat (4) @(negedge clk);
    check("R9 completes with ss high", buf_full, 1);
    check("R9 receive", rd_data, 8'h8A);
    check("R9 send", seen, 8'h71);
    host_read();
    ss_in = 1'b0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule